// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This combinational unit prepares the second operand of a 32-bit ALU and works out the shifter carry that the ALU may later latch as its carry flag. It has two input forms, chosen by `imm_form_i`. In the register form a 32-bit operand is moved by one of four shift types. The amount comes either from a 5-bit field carried in the instruction or from the low byte of a register. In the immediate form an 8-bit constant is rotated right by an even count, which is twice a 4-bit rotate field.

The carry-out is always the last bit that left the word. Three cases differ from a plain shift. An instruction-field amount of zero has a special meaning for the right shifts and for rotate. A register amount of zero leaves both the operand and the carry untouched. Register amounts of 32 or more saturate or wrap, depending on the shift type. Decode, the register file and the ALU lie outside the block. They drive its inputs and consume its two outputs in the same cycle.

Top module: `opnd_shifter`

## Requirements
- R1: Shift type encoding on `shtype_i` is 00 logical left, 01 logical right, 10 arithmetic right and 11 rotate right. A logical left by n in 1..31 gives the operand times 2^n, modulo 2^32. The carry is the operand bit at position 32-n.
- R2: A logical right by n in 1..31 fills with zeros, and an arithmetic right by n in 1..31 fills with the operand's bit 31. In both cases the carry is the operand bit at position n-1.
- R3: A rotate right by a nonzero amount whose low five bits are m wraps the bits leaving bit 0 into bit 31. The carry is bit 31 of the result, which is the last bit rotated out.
- R4: In the register form with the instruction-field amount selected (`use_reg_amt_i`=0), a rotate right with field value 0 is a one-bit rotate through carry. The result is {`carry_i`, operand[31:1]} and the carry is operand bit 0.
- R5: An instruction-field logical left of 0 passes the operand through unchanged, and the carry equals `carry_i`.
- R6: An instruction-field value of 0 for logical right or arithmetic right means a shift by 32. Logical right gives 0 with carry operand[31]. Arithmetic right gives 32 copies of operand[31] with carry operand[31].
- R7: With `use_reg_amt_i`=1 the amount is the 8-bit `reg_amt_i` and `field_amt_i` is ignored. An amount of 0 passes the operand through and keeps `carry_i`, for every shift type.
- R8: A register logical shift by exactly 32 gives 0. The carry is operand[0] for a left shift and operand[31] for a right shift. For amounts above 32 both the result and the carry are 0.
- R9: A register arithmetic right by 32 or more gives 32 copies of operand[31], with carry operand[31].
- R10: A register rotate by a nonzero multiple of 32 returns the operand unchanged, with carry operand[31]. Any other register rotate amount acts as the amount modulo 32.
- R11: In the immediate form (`imm_form_i`=1) the result is `imm8_i` zero-extended and rotated right by 2×`rot_i`. The carry is result bit 31 when `rot_i` is nonzero and `carry_i` when it is zero. The register-form inputs have no effect in this form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_i | input | 32 | Operand value for the register form |
| shtype_i | input | 2 | Shift type (see R1) |
| use_reg_amt_i | input | 1 | 1: amount from `reg_amt_i`; 0: from `field_amt_i` |
| field_amt_i | input | 5 | Shift amount held in the instruction |
| reg_amt_i | input | 8 | Low byte of the amount register |
| imm_form_i | input | 1 | 1 selects the rotated 8-bit constant |
| imm8_i | input | 8 | Constant for the immediate form |
| rot_i | input | 4 | Half the right-rotate count for the constant |
| carry_i | input | 1 | Incoming carry flag |
| opd_o | output | 32 | Prepared second operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench targets the places where the carry rule changes. These are the zero field amount, which means pass, shift-by-32 or rotate-through-carry depending on the shift type, and register amounts of 0, 32, just above 32, and large values. A design that treated field zero as a plain zero shift would return the operand for logical right of zero instead of 0. A design that treated register zero like field zero would run a rotate-through-carry when it should pass. Amounts of 32 and 33 tell apart a carry taken from bit 0 or bit 31 and a carry forced to zero. Multiples of 32 for rotate catch a carry left at `carry_i`. Immediate cases with rotate 0 and with nonzero rotates catch a design that drops the incoming carry or takes the carry from the wrong end.

// File: rtl/opnd_shifter.sv
module opnd_shifter #(
  parameter int W    = 32,
  parameter int SAW  = 5,
  parameter int RAW  = 8,
  parameter int IMMW = 8,
  parameter int ROTW = 4
) (
  input  logic [W-1:0]    opd_i,
  input  logic [1:0]      shtype_i,
  input  logic            use_reg_amt_i,
  input  logic [SAW-1:0]  field_amt_i,
  input  logic [RAW-1:0]  reg_amt_i,
  input  logic            imm_form_i,
  input  logic [IMMW-1:0] imm8_i,
  input  logic [ROTW-1:0] rot_i,
  input  logic            carry_i,
  output logic [W-1:0]    opd_o,
  output logic            carry_o
);
  localparam int NW = RAW + 1;
  localparam logic [1:0] SH_LSL = 2'b00;
  localparam logic [1:0] SH_LSR = 2'b01;
  localparam logic [1:0] SH_ASR = 2'b10;
  localparam logic [1:0] SH_ROR = 2'b11;
  localparam logic [NW-1:0] N_FULL = NW'(W);

  logic [NW-1:0]    n;
  logic [ROTW:0]    rot_amt;
  logic [2*W-1:0]   imm_dbl;
  logic [W-1:0]     imm_val;

  assign rot_amt = {rot_i, 1'b0};
  assign imm_dbl = {W'(imm8_i), W'(imm8_i)} >> rot_amt;
  assign imm_val = imm_dbl[W-1:0];

  always_comb begin
    if (use_reg_amt_i)
      n = NW'(reg_amt_i);
    else if (field_amt_i == '0 && (shtype_i == SH_LSR || shtype_i == SH_ASR))
      n = N_FULL;
    else
      n = NW'(field_amt_i);
  end

  logic [W:0]           t;
  logic signed [W:0]    ts;
  logic [2*W-1:0]       rdbl;
  logic [W-1:0]         res;
  logic                 cout;

  always_comb begin
    t    = '0;
    ts   = '0;
    rdbl = '0;
    res  = opd_i;
    cout = carry_i;
    if (imm_form_i) begin
      res  = imm_val;
      cout = (rot_i == '0) ? carry_i : imm_val[W-1];
    end else begin
      unique case (shtype_i)
        SH_LSL: begin
          if (n == '0) begin
            res  = opd_i;
            cout = carry_i;
          end else if (n < N_FULL) begin
            t    = {1'b0, opd_i} << n;
            res  = t[W-1:0];
            cout = t[W];
          end else begin
            res  = '0;
            cout = (n == N_FULL) ? opd_i[0] : 1'b0;
          end
        end
        SH_LSR: begin
          if (n == '0) begin
            res  = opd_i;
            cout = carry_i;
          end else if (n < N_FULL) begin
            t    = {opd_i, 1'b0} >> n;
            res  = t[W:1];
            cout = t[0];
          end else begin
            res  = '0;
            cout = (n == N_FULL) ? opd_i[W-1] : 1'b0;
          end
        end
        SH_ASR: begin
          if (n == '0) begin
            res  = opd_i;
            cout = carry_i;
          end else if (n < N_FULL) begin
            ts   = $signed({opd_i, 1'b0}) >>> n;
            res  = ts[W:1];
            cout = ts[0];
          end else begin
            res  = {W{opd_i[W-1]}};
            cout = opd_i[W-1];
          end
        end
        SH_ROR: begin
          if (!use_reg_amt_i && n == '0) begin
            res  = {carry_i, opd_i[W-1:1]};
            cout = opd_i[0];
          end else if (n == '0) begin
            res  = opd_i;
            cout = carry_i;
          end else begin
            rdbl = {opd_i, opd_i} >> n[SAW-1:0];
            res  = rdbl[W-1:0];
            cout = res[W-1];
          end
        end
        default: begin
          res  = opd_i;
          cout = carry_i;
        end
      endcase
    end

    if (imm_form_i)
      AST_IMM_POPCOUNT: assert ($countones(res) == $countones(imm8_i)); // R11
    if (!imm_form_i && use_reg_amt_i && reg_amt_i == '0)
      AST_REG_ZERO_PASS: assert (res == opd_i && cout == carry_i); // R7
    if (!imm_form_i && shtype_i == SH_ROR && use_reg_amt_i && reg_amt_i != '0)
      AST_ROR_POPCOUNT: assert ($countones(res) == $countones(opd_i) && cout == res[W-1]); // R3
    if (!imm_form_i && shtype_i == SH_ASR && use_reg_amt_i && NW'(reg_amt_i) >= N_FULL)
      AST_ASR_FILL: assert (($countones(res) == 0 || $countones(res) == W) && cout == res[0]); // R9
    if (!imm_form_i && !use_reg_amt_i && shtype_i == SH_ROR && field_amt_i == '0)
      AST_RRX_ONES: assert ($countones({res, cout}) == $countones({carry_i, opd_i})); // R4
  end

  assign opd_o   = res;
  assign carry_o = cout;
endmodule

// File: tb/sim_opnd_shifter.sv
module sim_opnd_shifter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] opd_i;
  logic [1:0]  shtype_i;
  logic        use_reg_amt_i;
  logic [4:0]  field_amt_i;
  logic [7:0]  reg_amt_i;
  logic        imm_form_i;
  logic [7:0]  imm8_i;
  logic [3:0]  rot_i;
  logic        carry_i;
  logic [31:0] opd_o;
  logic        carry_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  opnd_shifter u0 (
    .opd_i(opd_i), .shtype_i(shtype_i), .use_reg_amt_i(use_reg_amt_i),
    .field_amt_i(field_amt_i), .reg_amt_i(reg_amt_i), .imm_form_i(imm_form_i),
    .imm8_i(imm8_i), .rot_i(rot_i), .carry_i(carry_i),
    .opd_o(opd_o), .carry_o(carry_o)
  );

  task automatic chk(input string tag, input logic [31:0] eo, input logic ec);
    @(negedge clk);
    n_run++;
    if (opd_o !== eo || carry_o !== ec) begin
      n_fail++;
      $display("FAIL %s: got %h/%b expected %h/%b", tag, opd_o, carry_o, eo, ec);
    end
  endtask

  task automatic reg_form(input logic [31:0] v, input logic [1:0] st, input logic ur,
                          input logic [4:0] fa, input logic [7:0] ra, input logic ci);
    imm_form_i = 1'b0; opd_i = v; shtype_i = st; use_reg_amt_i = ur;
    field_amt_i = fa; reg_amt_i = ra; carry_i = ci;
    imm8_i = 8'h5A; rot_i = 4'h7;
  endtask

  task automatic imm_form(input logic [7:0] k, input logic [3:0] r, input logic ci);
    imm_form_i = 1'b1; imm8_i = k; rot_i = r; carry_i = ci;
    opd_i = 32'hDEAD_BEEF; shtype_i = 2'b10; use_reg_amt_i = 1'b1;
    field_amt_i = 5'd3; reg_amt_i = 8'd7;
  endtask

  task automatic t_reset_state;
    reg_form(32'h0000_0000, 2'b00, 1'b0, 5'd0, 8'd0, 1'b0);
    chk("R5 idle zero", 32'h0, 1'b0);
  endtask

  task automatic t_left;
    reg_form(32'hF000_000F, 2'b00, 1'b0, 5'd4, 8'd0, 1'b0);
    chk("R1 lsl4", 32'h0000_00F0, 1'b1);
    reg_form(32'h0000_0003, 2'b00, 1'b1, 5'd0, 8'd31, 1'b0);
    chk("R1 lsl31 reg", 32'h8000_0000, 1'b1);
    reg_form(32'hF000_000F, 2'b00, 1'b0, 5'd0, 8'd0, 1'b1);
    chk("R5 lsl0 c1", 32'hF000_000F, 1'b1);
    reg_form(32'hF000_000F, 2'b00, 1'b0, 5'd0, 8'd0, 1'b0);
    chk("R5 lsl0 c0", 32'hF000_000F, 1'b0);
  endtask

  task automatic t_right;
    reg_form(32'h8000_0010, 2'b01, 1'b0, 5'd4, 8'd0, 1'b1);
    chk("R2 lsr4", 32'h0800_0001, 1'b0);
    reg_form(32'h8000_0010, 2'b01, 1'b0, 5'd5, 8'd0, 1'b0);
    chk("R2 lsr5", 32'h0400_0000, 1'b1);
    reg_form(32'h8000_0010, 2'b10, 1'b0, 5'd4, 8'd0, 1'b1);
    chk("R2 asr4", 32'hF800_0001, 1'b0);
    reg_form(32'h8000_0010, 2'b10, 1'b0, 5'd5, 8'd0, 1'b0);
    chk("R2 asr5", 32'hFC00_0000, 1'b1);
  endtask

  task automatic t_field_zero_is_32;
    reg_form(32'h8000_0000, 2'b01, 1'b0, 5'd0, 8'd0, 1'b0);
    chk("R6 lsr#0", 32'h0, 1'b1);
    reg_form(32'h8000_0000, 2'b10, 1'b0, 5'd0, 8'd0, 1'b0);
    chk("R6 asr#0 neg", 32'hFFFF_FFFF, 1'b1);
    reg_form(32'h7FFF_FFFF, 2'b10, 1'b0, 5'd0, 8'd0, 1'b1);
    chk("R6 asr#0 pos", 32'h0, 1'b0);
  endtask

  task automatic t_rotate;
    reg_form(32'h0000_0012, 2'b11, 1'b0, 5'd4, 8'd0, 1'b1);
    chk("R3 ror4", 32'h2000_0001, 1'b0);
    reg_form(32'h0000_0013, 2'b11, 1'b0, 5'd1, 8'd0, 1'b0);
    chk("R3 ror1", 32'h8000_0009, 1'b1);
    reg_form(32'h0000_0003, 2'b11, 1'b0, 5'd0, 8'd0, 1'b1);
    chk("R4 rrx c1", 32'h8000_0001, 1'b1);
    reg_form(32'h0000_0002, 2'b11, 1'b0, 5'd0, 8'd0, 1'b0);
    chk("R4 rrx c0", 32'h0000_0001, 1'b0);
  endtask

  task automatic t_reg_zero;
    for (int s = 0; s < 4; s++) begin
      reg_form(32'h1234_5678, 2'(s), 1'b1, 5'd9, 8'd0, s[0]);
      chk("R7 reg amt 0", 32'h1234_5678, s[0]);
    end
    reg_form(32'h1234_5678, 2'b00, 1'b1, 5'd0, 8'd4, 1'b0);
    chk("R7 field ignored", 32'h2345_6780, 1'b1);
  endtask

  task automatic t_reg_large;
    reg_form(32'h0000_0001, 2'b00, 1'b1, 5'd0, 8'd32, 1'b0);
    chk("R8 lsl32", 32'h0, 1'b1);
    reg_form(32'hFFFF_FFFF, 2'b00, 1'b1, 5'd0, 8'd33, 1'b1);
    chk("R8 lsl33", 32'h0, 1'b0);
    reg_form(32'h8000_0000, 2'b01, 1'b1, 5'd0, 8'd32, 1'b0);
    chk("R8 lsr32", 32'h0, 1'b1);
    reg_form(32'hFFFF_FFFF, 2'b01, 1'b1, 5'd0, 8'd40, 1'b1);
    chk("R8 lsr40", 32'h0, 1'b0);
    reg_form(32'h8000_0000, 2'b10, 1'b1, 5'd0, 8'd200, 1'b0);
    chk("R9 asr200", 32'hFFFF_FFFF, 1'b1);
    reg_form(32'h4000_0000, 2'b10, 1'b1, 5'd0, 8'd32, 1'b1);
    chk("R9 asr32", 32'h0, 1'b0);
    reg_form(32'h0000_0012, 2'b11, 1'b1, 5'd0, 8'd36, 1'b1);
    chk("R10 ror36", 32'h2000_0001, 1'b0);
    reg_form(32'h8000_0001, 2'b11, 1'b1, 5'd0, 8'd32, 1'b0);
    chk("R10 ror32", 32'h8000_0001, 1'b1);
    reg_form(32'h4000_0001, 2'b11, 1'b1, 5'd0, 8'd64, 1'b1);
    chk("R10 ror64", 32'h4000_0001, 1'b0);
  endtask

  task automatic t_immediate;
    imm_form(8'hFF, 4'd0, 1'b1);
    chk("R11 rot0 c1", 32'h0000_00FF, 1'b1);
    imm_form(8'hFF, 4'd0, 1'b0);
    chk("R11 rot0 c0", 32'h0000_00FF, 1'b0);
    imm_form(8'hFF, 4'd1, 1'b0);
    chk("R11 ror2", 32'hC000_003F, 1'b1);
    imm_form(8'h40, 4'd13, 1'b1);
    chk("R11 ror26", 32'h0000_1000, 1'b0);
    imm_form(8'h02, 4'd1, 1'b0);
    chk("R11 top bit", 32'h8000_0000, 1'b1);
  endtask

  initial begin
    t_reset_state();
    t_left();
    t_right();
    t_field_zero_is_32();
    t_rotate();
    t_reg_zero();
    t_reg_large();
    t_immediate();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule